// File: doc/BRIEF.md
# DDR Mode Register Command Handler

This block sits on the device side of a DDR SDRAM command interface. Each clock it samples the chip-select, row-strobe, column-strobe and write-enable lines with the two bank-address bits and the 13-bit address bus. It watches for mode register writes. A write is accepted only when every bank is idle and clock enable was high at the previous edge. The address word is then latched into the base or the extended mode register, chosen by bank address bit 0.

The stored base word is decoded into burst length, burst type, CAS latency in half-cycle units and an operating mode. A write that requests a DLL reset produces a one-cycle pulse. After every accepted write the block holds a two-cycle lockout. Any real command issued during the lockout is flagged. Sticky flags report reserved field codes and protocol violations. The command pins are plain per-cycle control inputs, so there is no stream handshake and no back-pressure.

Top module: `mrs_cmd_handler`

## Requirements
- R1: A mode register write is decoded when cs_n, ras_n, cas_n and we_n are all low and ba[1] is 0. ba[0]=0 writes base_word and ba[0]=1 writes ext_word, both visible one cycle after the sampling edge. All four strobes low with ba[1]=1 is not a write and changes nothing.
- R2: A write is accepted only if banks_idle is high and cke was high at the previous clock edge. Otherwise it is ignored and violation goes high.
- R3: busy is high for exactly the two cycles after an accepted write. A command sampled while busy is ignored and sets violation, unless it is a no-operation (cs_n=0, ras_n=cas_n=we_n=1) or a deselect (cs_n=1).
- R4: base_word and ext_word hold their values until an accepted write to that register.
- R5: burst_len decodes base_word[2:0]: 001 gives 2, 010 gives 4, 011 gives 8, and any other code gives 0 (reserved).
- R6: burst_interleave equals base_word[3]: 0 means sequential and 1 means interleaved.
- R7: cas_lat_half gives the CAS latency in half cycles from base_word[6:4]: 101 gives 3, 010 gives 4, 110 gives 5, 011 gives 6, and any other code gives 0.
- R8: op_mode decodes base_word[12:7]: all zero gives 0 (normal), only bit 8 set gives 1 (normal with DLL reset), only bit 7 set gives 2 (test), and any other pattern gives 3 (reserved).
- R9: dll_reset_pulse is high for exactly one cycle, the cycle after an accepted base write whose operating mode is the DLL reset code.
- R10: reserved_code is set by an accepted base write that carries a reserved burst length, CAS latency or operating mode code. It is cleared by an accepted base write with all codes valid, or by reset. Extended writes leave it unchanged.
- R11: violation is sticky. It is cleared only by reset or by the next accepted write.
- R12: While rst_n is low (synchronous, active low), base_word becomes 13'h032 (burst 4, CAS 3, sequential, normal), ext_word becomes 0, and all flags and busy become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address; bit 0 picks the register |
| addr | input | 13 | Address bus carrying the register word |
| banks_idle | input | 1 | High when every bank is idle |
| base_word | output | 13 | Stored base mode register |
| ext_word | output | 13 | Stored extended mode register |
| burst_len | output | 4 | Burst length, 0 if reserved |
| burst_interleave | output | 1 | Burst type, 1 means interleaved |
| cas_lat_half | output | 3 | CAS latency in half cycles, 0 if reserved |
| op_mode | output | 2 | Operating mode code |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| reserved_code | output | 1 | Sticky reserved-code flag |
| violation | output | 1 | Sticky protocol-violation flag |
| busy | output | 1 | Post-write lockout active |

## Verification
The properties assume the command pins and banks_idle are stable and known at each rising edge. They also assume the reset is held for at least one edge before any command is issued. The stimulus drives every input on the falling edge and releases reset only on a falling edge. Each phase starts with no-operation cycles at cke high, so the clock-enable history seen by a write is always the one the bench intends. The lockout properties assume that a write cannot be accepted while the lockout runs. The bench tests this by issuing a second write and an activate inside the window.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int ADDR_W = 13;
  localparam int NUM_MR = 2;

  typedef enum logic [1:0] {
    OPM_NORMAL  = 2'd0,
    OPM_DLL_RST = 2'd1,
    OPM_TEST    = 2'd2,
    OPM_RSVD    = 2'd3
  } opmode_e;

  typedef struct packed {
    logic [3:0] blen;
    logic       interleave;
    logic [2:0] cl_half;
    opmode_e    opm;
    logic       rsvd;
  } mr_fields_t;
endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode (
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ba_hi,
  output logic is_mrs,
  output logic is_cmd
);
  logic strobes_low;
  logic is_nop;

  always_comb begin
    strobes_low = !ras_n && !cas_n && !we_n;
    is_nop      = ras_n && cas_n && we_n;
    // a real command: selected and not a no-operation
    is_cmd      = !cs_n && !is_nop;
    is_mrs      = !cs_n && strobes_low && !ba_hi;
  end
endmodule

// File: rtl/mrs_gatekeeper.sv
module mrs_gatekeeper #(
  parameter int LOCK_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic banks_idle,
  input  logic is_mrs,
  input  logic is_cmd,
  output logic accept,
  output logic busy,
  output logic violation
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] lock_q;
  logic          cke_q;
  logic          viol_q;
  logic          lock_hit;
  logic          illegal;

  assign busy      = (lock_q != '0);
  assign violation = viol_q;

  always_comb begin
    lock_hit = busy && is_cmd;
    accept   = !busy && is_mrs && banks_idle && cke_q;
    illegal  = !busy && is_mrs && !(banks_idle && cke_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= '0;
      cke_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      cke_q <= cke;
      if (accept)
        lock_q <= CW'(LOCK_CYCLES);
      else if (busy)
        lock_q <= lock_q - 1'b1;
      if (lock_hit || illegal)
        viol_q <= 1'b1;
      else if (accept)
        viol_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
  import mrs_pkg::*;
(
  input  logic [ADDR_W-1:0] word,
  output mr_fields_t        fields
);
  always_comb begin
    fields = '0;
    unique case (word[2:0])
      3'b001:  fields.blen = 4'd2;
      3'b010:  fields.blen = 4'd4;
      3'b011:  fields.blen = 4'd8;
      default: fields.blen = 4'd0;
    endcase
    fields.interleave = word[3];
    unique case (word[6:4])
      3'b101:  fields.cl_half = 3'd3;
      3'b010:  fields.cl_half = 3'd4;
      3'b110:  fields.cl_half = 3'd5;
      3'b011:  fields.cl_half = 3'd6;
      default: fields.cl_half = 3'd0;
    endcase
    unique case (word[ADDR_W-1:7])
      6'b000000: fields.opm = OPM_NORMAL;
      6'b000010: fields.opm = OPM_DLL_RST;
      6'b000001: fields.opm = OPM_TEST;
      default:   fields.opm = OPM_RSVD;
    endcase
    fields.rsvd = (fields.blen == 4'd0) || (fields.cl_half == 3'd0) ||
                  (fields.opm == OPM_RSVD);
  end
endmodule

// File: rtl/mrs_reg_bank.sv
module mrs_reg_bank
  import mrs_pkg::*;
#(
  parameter int              NREG      = NUM_MR,
  parameter logic [ADDR_W-1:0] BASE_INIT = 13'h032
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic [SW-1:0]              sel,
  input  logic [ADDR_W-1:0]          wdata,
  input  mr_fields_t                 wfields,
  output logic [NREG-1:0][ADDR_W-1:0] words,
  output logic                       dll_pulse,
  output logic                       rsvd_flag
);
  localparam int SW = (NREG > 1) ? $clog2(NREG) : 1;

  logic base_wr;
  assign base_wr = accept && (sel == '0);

  for (genvar g = 0; g < NREG; g++) begin : g_mr
    localparam logic [ADDR_W-1:0] INIT = (g == 0) ? BASE_INIT : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[g] <= INIT;
      else if (accept && (sel == SW'(g)))
        words[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll_pulse <= 1'b0;
      rsvd_flag <= 1'b0;
    end else begin
      dll_pulse <= base_wr && (wfields.opm == OPM_DLL_RST);
      if (base_wr)
        rsvd_flag <= wfields.rsvd;
    end
  end
endmodule

// File: rtl/mrs_cmd_handler.sv
module mrs_cmd_handler
  import mrs_pkg::*;
#(
  parameter int                LOCK_CYCLES = 2,
  parameter logic [ADDR_W-1:0] RESET_MR    = 13'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  output logic [ADDR_W-1:0] base_word,
  output logic [ADDR_W-1:0] ext_word,
  output logic [3:0]        burst_len,
  output logic              burst_interleave,
  output logic [2:0]        cas_lat_half,
  output logic [1:0]        op_mode,
  output logic              dll_reset_pulse,
  output logic              reserved_code,
  output logic              violation,
  output logic              busy
);
  logic is_mrs_w;
  logic is_cmd_w;
  logic acc_w;
  mr_fields_t wr_fields;
  mr_fields_t cur_fields;
  logic [NUM_MR-1:0][ADDR_W-1:0] words_w;

  mrs_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba_hi (ba[1]),
    .is_mrs(is_mrs_w),
    .is_cmd(is_cmd_w)
  );

  mrs_gatekeeper #(.LOCK_CYCLES(LOCK_CYCLES)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .banks_idle(banks_idle),
    .is_mrs    (is_mrs_w),
    .is_cmd    (is_cmd_w),
    .accept    (acc_w),
    .busy      (busy),
    .violation (violation)
  );

  mrs_field_decode u_wr_dec (
    .word  (addr),
    .fields(wr_fields)
  );

  mrs_reg_bank #(.NREG(NUM_MR), .BASE_INIT(RESET_MR)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (acc_w),
    .sel      (ba[0]),
    .wdata    (addr),
    .wfields  (wr_fields),
    .words    (words_w),
    .dll_pulse(dll_reset_pulse),
    .rsvd_flag(reserved_code)
  );

  mrs_field_decode u_cur_dec (
    .word  (words_w[0]),
    .fields(cur_fields)
  );

  assign base_word        = words_w[0];
  assign ext_word         = words_w[1];
  assign burst_len        = cur_fields.blen;
  assign burst_interleave = cur_fields.interleave;
  assign cas_lat_half     = cur_fields.cl_half;
  assign op_mode          = cur_fields.opm;
endmodule

// File: rtl/mrs_cmd_handler_chk.sv
module mrs_cmd_handler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        is_mrs,
  input logic        is_cmd,
  input logic        banks_idle,
  input logic [1:0]  ba,
  input logic        busy,
  input logic        violation,
  input logic        dll_reset_pulse,
  input logic [2:0]  cas_lat_half,
  input logic [12:0] base_word,
  input logic [12:0] ext_word
);
  // R3: an accepted write opens the lockout window
  p_busy_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R3: a real command inside the window is flagged
  p_lock_violation_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_cmd) |=> violation);

  // R2: a write with banks active is flagged
  p_illegal_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && !busy && !banks_idle) |=> violation);

  // R4: the base register holds without a base write
  p_hold_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && !ba[0]) |=> $stable(base_word));

  // R4: the extended register holds without an extended write
  p_hold_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && ba[0]) |=> $stable(ext_word));

  // R9: the DLL reset request lasts one cycle
  p_dll_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |=> !dll_reset_pulse);

  // R7: only legal half-cycle latencies or the reserved zero appear
  p_cl_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cas_lat_half inside {3'd0, 3'd3, 3'd4, 3'd5, 3'd6});
endmodule

bind mrs_cmd_handler mrs_cmd_handler_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .accept         (acc_w),
  .is_mrs         (is_mrs_w),
  .is_cmd         (is_cmd_w),
  .banks_idle     (banks_idle),
  .ba             (ba),
  .busy           (busy),
  .violation      (violation),
  .dll_reset_pulse(dll_reset_pulse),
  .cas_lat_half   (cas_lat_half),
  .base_word      (base_word),
  .ext_word       (ext_word)
);

// File: tb/mrs_cmd_handler_test.sv
module mrs_cmd_handler_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'b00;
  logic [12:0] addr = '0;
  logic        banks_idle = 1'b1;
  logic [12:0] base_word, ext_word;
  logic [3:0]  burst_len;
  logic        burst_interleave;
  logic [2:0]  cas_lat_half;
  logic [1:0]  op_mode;
  logic        dll_reset_pulse, reserved_code, violation, busy;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  mrs_cmd_handler uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .base_word(base_word), .ext_word(ext_word), .burst_len(burst_len),
    .burst_interleave(burst_interleave), .cas_lat_half(cas_lat_half),
    .op_mode(op_mode), .dll_reset_pulse(dll_reset_pulse),
    .reserved_code(reserved_code), .violation(violation), .busy(busy)
  );

  typedef struct {
    logic [12:0] base;
    logic [12:0] ext;
    logic        dll;
    logic        resv;
    logic        viol;
    logic        busy;
    string       tag;
  } exp_t;

  exp_t q[$];

  // reference model state
  logic [12:0] m_base, m_ext;
  logic        m_resv, m_viol, m_ckep, m_dll;
  int          m_lock;

  function automatic logic [3:0] ref_bl(input logic [12:0] w);
    case (w[2:0]) 3'b001: return 4'd2; 3'b010: return 4'd4;
      3'b011: return 4'd8; default: return 4'd0; endcase
  endfunction
  function automatic logic [2:0] ref_cl(input logic [12:0] w);
    case (w[6:4]) 3'b101: return 3'd3; 3'b010: return 3'd4;
      3'b110: return 3'd5; 3'b011: return 3'd6; default: return 3'd0; endcase
  endfunction
  function automatic logic [1:0] ref_op(input logic [12:0] w);
    case (w[12:7]) 6'b000000: return 2'd0; 6'b000010: return 2'd1;
      6'b000001: return 2'd2; default: return 2'd3; endcase
  endfunction

  task automatic model_reset();
    m_base = 13'h032; m_ext = '0; m_resv = 0; m_viol = 0;
    m_ckep = 0; m_dll = 0; m_lock = 0;
  endtask

  task automatic fail_line(input string tag, input string what, input int act, input int e);
    bad++;
    $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, e);
  endtask

  task automatic compare(input exp_t e);
    total++;
    if (base_word !== e.base) fail_line(e.tag, "base_word", base_word, e.base);
    if (ext_word !== e.ext) fail_line(e.tag, "ext_word", ext_word, e.ext);
    if (burst_len !== ref_bl(e.base)) fail_line(e.tag, "burst_len R5", burst_len, ref_bl(e.base));
    if (burst_interleave !== e.base[3]) fail_line(e.tag, "interleave R6", burst_interleave, e.base[3]);
    if (cas_lat_half !== ref_cl(e.base)) fail_line(e.tag, "cas_lat R7", cas_lat_half, ref_cl(e.base));
    if (op_mode !== ref_op(e.base)) fail_line(e.tag, "op_mode R8", op_mode, ref_op(e.base));
    if (dll_reset_pulse !== e.dll) fail_line(e.tag, "dll R9", dll_reset_pulse, e.dll);
    if (reserved_code !== e.resv) fail_line(e.tag, "reserved R10", reserved_code, e.resv);
    if (violation !== e.viol) fail_line(e.tag, "violation R11", violation, e.viol);
    if (busy !== e.busy) fail_line(e.tag, "busy R3", busy, e.busy);
  endtask

  function automatic exp_t snap(input string tag);
    exp_t e;
    e.base = m_base; e.ext = m_ext; e.dll = m_dll; e.resv = m_resv;
    e.viol = m_viol; e.busy = (m_lock > 0); e.tag = tag;
    return e;
  endfunction

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic c, input logic r, input logic ca, input logic w,
                      input logic [1:0] b, input logic [12:0] a,
                      input logic idle, input logic ck, input string tag);
    logic is_cmd, is_mrs;
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    banks_idle = idle; cke = ck;
    is_cmd = !c && !(r && ca && w);
    is_mrs = !c && !r && !ca && !w && !b[1];
    m_dll = 0;
    if (m_lock > 0) begin
      if (is_cmd) m_viol = 1;
      m_lock--;
    end else if (is_mrs) begin
      if (idle && m_ckep) begin
        if (b[0]) m_ext = a;
        else begin
          m_base = a;
          m_resv = (ref_bl(a) == 0) || (ref_cl(a) == 0) || (ref_op(a) == 2'd3);
          m_dll  = (ref_op(a) == 2'd1);
        end
        m_viol = 0;
        m_lock = 2;
      end else m_viol = 1;
    end
    m_ckep = ck;
    q.push_back(snap(tag));
  endtask

  task automatic nop(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 1, 1, 1, 2'b00, '0, 1, 1, tag);
  endtask
  task automatic mrs(input logic [1:0] b, input logic [12:0] a, input string tag);
    step(0, 0, 0, 0, b, a, 1, 1, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cs_n = 1; cke = 0;
    repeat (2) @(posedge clk);
    #(PERIOD/4);
    model_reset();
    compare(snap("R12 reset state"));
    @(negedge clk);
    rst_n = 1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    nop(2, "R12 idle after reset");
    mrs(2'b00, 13'h022, "R1 R5 R7 base write BL4 CL2");
    nop(2, "R3 lockout nop");
    nop(1, "R3 lockout over");
    mrs(2'b01, 13'h0001, "R1 ext write");
    step(1, 0, 0, 0, 2'b00, '0, 1, 1, "R3 deselect in lockout");
    nop(2, "R4 hold");
    mrs(2'b00, 13'h016B, "R6 R8 R9 BL8 interleave CL2.5 dll");
    nop(3, "R9 pulse ends");
    mrs(2'b00, 13'h0033, "R7 CL3 BL8");
    step(0, 0, 1, 1, 2'b00, '0, 1, 1, "R3 activate in lockout");
    mrs(2'b00, 13'h0022, "R3 write in lockout ignored");
    nop(2, "R11 violation sticky");
    mrs(2'b00, 13'h00D1, "R11 R7 R8 R5 clear CL1.5 test BL2");
    nop(2, "R4 hold after write");
    step(0, 0, 0, 0, 2'b00, 13'h0022, 0, 1, "R2 banks busy ignored");
    nop(1, "R2 sticky");
    step(0, 0, 0, 0, 2'b10, 13'h0022, 1, 1, "R1 ba1 high not a write");
    nop(1, "R1 ba1 no effect");
    step(0, 1, 1, 1, 2'b00, '0, 1, 0, "R2 cke low");
    mrs(2'b00, 13'h0022, "R2 cke low previous ignored");
    mrs(2'b00, 13'h0020, "R10 reserved BL accepted");
    nop(2, "R10 flag holds");
    mrs(2'b01, 13'h0040, "R10 ext write keeps flag");
    nop(2, "R10 hold");
    mrs(2'b00, 13'h0003, "R10 reserved CL");
    nop(2, "R10 hold");
    mrs(2'b00, 13'h0222, "R10 R8 reserved op mode");
    nop(2, "R10 hold");
    mrs(2'b00, 13'h0032, "R10 valid write clears");
    nop(3, "R10 cleared");
    do_reset();
    nop(1, "R12 after second reset");
    @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule